// File: doc/BRIEF.md
# Debounced LED Grid Cursor

This block keeps a single lit position on an LED grid of four rows and two columns. Four direction buttons and a centre button steer it. All five button inputs come straight from mechanical switches. Each one is brought into the clock domain through a short flip-flop chain. It then passes through its own debounce counter, so a press is accepted only once the level has held for a programmable number of cycles. One accepted press moves the cursor exactly once, however long the button is kept down.

The cursor saturates at every edge of the grid. The centre button sends it back to the top row of the first column. The block drives a registered one-hot LED vector, so exactly one LED is lit at all times. With a 25 MHz clock, the hold time of 25 ms corresponds to the default of 625,000 cycles. A testbench can shorten that count through the parameter.

Top module: `grid_cursor`

## Requirements
- R1: A synchronous reset places the cursor at position 0, so `led_out` is 8'h80, and clears every synchroniser and debounce register. A button held across reset is therefore accepted again as a fresh press once reset is released.
- R2: `led_out` is always one-hot. The position is numbered column*4 + row, with rows 0..3 top to bottom and columns 0..1. Position p lights bit 7-p.
- R3: A button level is acted on only after it has stayed constant, past the synchroniser, for HOLD_CYCLES consecutive cycles. A pulse or bounce shorter than that causes no move, and any change of level restarts the count.
- R4: Each accepted press, which is a rising edge of the debounced level, moves the cursor exactly once. Holding the button for any length of time produces no further move.
- R5: Right moves from column 0 to the same row of column 1. Right in column 1 leaves the position unchanged.
- R6: Left moves from column 1 to the same row of column 0. Left in column 0 leaves the position unchanged.
- R7: Up decrements the row and leaves row 0 unchanged.
- R8: Down increments the row and leaves row 3 unchanged.
- R9: Centre returns the cursor to position 0 from any position.
- R10: When presses are accepted in the same cycle, only one is acted on. The priority is centre, then up, then down, then left, then right.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, the only clock edge used |
| rst | input | 1 | Synchronous active-high reset |
| btn_home | input | 1 | Raw centre button, active high |
| btn_up | input | 1 | Raw up button, active high |
| btn_down | input | 1 | Raw down button, active high |
| btn_left | input | 1 | Raw left button, active high |
| btn_right | input | 1 | Raw right button, active high |
| led_out | output | 8 | Registered one-hot LED vector, bit 7 is position 0 |

## Verification
The bench places the cursor at each of the eight positions in turn and applies every button from there. This covers every saturating edge: a design that wraps instead of clamping would light the wrong LED or the other column. Short pulses and a burst of bounces ahead of a genuine press probe the debounce. A counter that did not restart would accept a glitch, and one that fired on every bounce edge would move the cursor several steps. A button held for many hold periods checks that there is no auto-repeat. Paired simultaneous presses check the priority order: a design with a different order moves toward the losing button. Asserting reset while a button is held checks that the debounced level is cleared. A design that kept the level would miss the press that follows reset.

// File: rtl/grid_cursor_pkg.sv
package grid_cursor_pkg;
  localparam int NUM_BTNS  = 5;
  localparam int BTN_HOME  = 0;
  localparam int BTN_UP    = 1;
  localparam int BTN_DOWN  = 2;
  localparam int BTN_LEFT  = 3;
  localparam int BTN_RIGHT = 4;
  typedef logic [NUM_BTNS-1:0] btn_vec_t;
endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], raw_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int HOLD_CYCLES = 625000
) (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic press_o
);
  localparam int CNT_W = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             stable_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      stable_q <= 1'b0;
      press_o  <= 1'b0;
    end else begin
      press_o <= 1'b0;
      if (level_i == stable_q) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        cnt_q    <= '0;
        stable_q <= level_i;
        press_o  <= level_i;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/led_onehot.sv
module led_onehot #(
  parameter int NUM_POS = 8,
  localparam int POS_W = $clog2(NUM_POS)
) (
  input  logic [POS_W-1:0]   pos_i,
  output logic [NUM_POS-1:0] led_o
);
  always_comb begin
    for (int i = 0; i < NUM_POS; i++) begin
      led_o[NUM_POS-1-i] = (pos_i == POS_W'(i));
    end
  end
endmodule

// File: rtl/cursor_step.sv
module cursor_step
  import grid_cursor_pkg::*;
#(
  parameter int NUM_ROWS = 4,
  parameter int NUM_COLS = 2,
  localparam int NUM_POS = NUM_ROWS * NUM_COLS
) (
  input  logic               clk,
  input  logic               rst,
  input  btn_vec_t           press_i,
  output logic [NUM_POS-1:0] led_o
);
  localparam int ROW_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;
  localparam int COL_W = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1;
  localparam int POS_W = $clog2(NUM_POS);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(NUM_ROWS - 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(NUM_COLS - 1);
  localparam logic [NUM_POS-1:0] HOME_LED = {1'b1, {(NUM_POS-1){1'b0}}};

  logic [ROW_W-1:0]   row_q, row_n;
  logic [COL_W-1:0]   col_q, col_n;
  logic [POS_W-1:0]   pos_n;
  logic [NUM_POS-1:0] led_n;

  always_comb begin
    row_n = row_q;
    col_n = col_q;
    if (press_i[BTN_HOME]) begin
      row_n = '0;
      col_n = '0;
    end else if (press_i[BTN_UP]) begin
      if (row_q != '0) row_n = row_q - ROW_W'(1);
    end else if (press_i[BTN_DOWN]) begin
      if (row_q != ROW_LAST) row_n = row_q + ROW_W'(1);
    end else if (press_i[BTN_LEFT]) begin
      if (col_q != '0) col_n = col_q - COL_W'(1);
    end else if (press_i[BTN_RIGHT]) begin
      if (col_q != COL_LAST) col_n = col_q + COL_W'(1);
    end
    pos_n = POS_W'(int'(col_n) * NUM_ROWS + int'(row_n));
  end

  led_onehot #(.NUM_POS(NUM_POS)) u_dec (
    .pos_i (pos_n),
    .led_o (led_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q <= '0;
      col_q <= '0;
      led_o <= HOME_LED;
    end else begin
      row_q <= row_n;
      col_q <= col_n;
      led_o <= led_n;
    end
  end
endmodule

// File: rtl/grid_cursor.sv
module grid_cursor
  import grid_cursor_pkg::*;
#(
  parameter int NUM_ROWS    = 4,
  parameter int NUM_COLS    = 2,
  parameter int HOLD_CYCLES = 625000,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_POS    = NUM_ROWS * NUM_COLS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               btn_home,
  input  logic               btn_up,
  input  logic               btn_down,
  input  logic               btn_left,
  input  logic               btn_right,
  output logic [NUM_POS-1:0] led_out
);
  btn_vec_t raw_btn;
  btn_vec_t sync_btn;
  btn_vec_t press_pulse;

  always_comb begin
    raw_btn            = '0;
    raw_btn[BTN_HOME]  = btn_home;
    raw_btn[BTN_UP]    = btn_up;
    raw_btn[BTN_DOWN]  = btn_down;
    raw_btn[BTN_LEFT]  = btn_left;
    raw_btn[BTN_RIGHT] = btn_right;
  end

  for (genvar b = 0; b < NUM_BTNS; b++) begin : g_btn
    btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .raw_i  (raw_btn[b]),
      .sync_o (sync_btn[b])
    );
    btn_debounce #(.HOLD_CYCLES(HOLD_CYCLES)) u_db (
      .clk     (clk),
      .rst     (rst),
      .level_i (sync_btn[b]),
      .press_o (press_pulse[b])
    );
  end

  cursor_step #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)) u_step (
    .clk     (clk),
    .rst     (rst),
    .press_i (press_pulse),
    .led_o   (led_out)
  );
endmodule

// File: rtl/grid_cursor_chk.sv
module grid_cursor_chk #(
  parameter int LED_W    = 8,
  parameter int NUM_ROWS = 4,
  parameter int NUM_BTNS = 5
) (
  input logic                clk,
  input logic                rst,
  input logic [LED_W-1:0]    led_out,
  input logic [NUM_BTNS-1:0] press_pulse
);
  localparam logic [LED_W-1:0] HOME_LED = {1'b1, {(LED_W-1){1'b0}}};

  AST_RESET_HOME: assert property (@(posedge clk)
    rst |=> (led_out == HOME_LED)); // R1

  AST_LED_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(led_out) == 1); // R2

  AST_NO_MOVE_WITHOUT_PRESS: assert property (@(posedge clk) disable iff (rst)
    (press_pulse == '0) |=> $stable(led_out)); // R3

  AST_PRESS_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (press_pulse != '0) |=> ((press_pulse & $past(press_pulse)) == '0)); // R4

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(led_out) |-> ((led_out == HOME_LED) ||
                           (led_out == ($past(led_out) << 1)) ||
                           (led_out == ($past(led_out) >> 1)) ||
                           (led_out == ($past(led_out) << NUM_ROWS)) ||
                           (led_out == ($past(led_out) >> NUM_ROWS)))); // R4
endmodule

bind grid_cursor grid_cursor_chk #(
  .LED_W    (NUM_POS),
  .NUM_ROWS (NUM_ROWS),
  .NUM_BTNS (grid_cursor_pkg::NUM_BTNS)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .led_out     (led_out),
  .press_pulse (press_pulse)
);

// File: tb/grid_cursor_bench.sv
`timescale 1ns/1ps
module grid_cursor_bench;
  localparam int HOLD = 8;
  localparam logic [4:0] M_HOME  = 5'b00001;
  localparam logic [4:0] M_UP    = 5'b00010;
  localparam logic [4:0] M_DOWN  = 5'b00100;
  localparam logic [4:0] M_LEFT  = 5'b01000;
  localparam logic [4:0] M_RIGHT = 5'b10000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] btn = '0;
  logic [7:0] led_out;
  int vectors = 0;
  int fails   = 0;
  int mrow = 0;
  int mcol = 0;

  always #2.5 clk = ~clk;

  grid_cursor #(.HOLD_CYCLES(HOLD)) u_grid_cursor (
    .clk       (clk),
    .rst       (rst),
    .btn_home  (btn[0]),
    .btn_up    (btn[1]),
    .btn_down  (btn[2]),
    .btn_left  (btn[3]),
    .btn_right (btn[4]),
    .led_out   (led_out)
  );

  function automatic logic [7:0] exp_led();
    return 8'h80 >> (mcol * 4 + mrow);
  endfunction

  task automatic model_apply(input logic [4:0] m);
    if (m[0]) begin mrow = 0; mcol = 0; end
    else if (m[1]) begin if (mrow > 0) mrow--; end
    else if (m[2]) begin if (mrow < 3) mrow++; end
    else if (m[3]) begin if (mcol > 0) mcol--; end
    else if (m[4]) begin if (mcol < 1) mcol++; end
  endtask

  task automatic check(input string req, input logic [7:0] exp);
    vectors++;
    if (led_out !== exp) begin
      fails++;
      $display("FAIL %s: led_out=%h expected %h", req, led_out, exp);
    end
  endtask

  task automatic press(input logic [4:0] m, input int hi);
    btn = m;
    repeat (hi) @(negedge clk);
    btn = '0;
    repeat (HOLD + 8) @(negedge clk);
    if (hi >= HOLD + 4) model_apply(m);
  endtask

  task automatic goto_pos(input int r, input int c);
    press(M_HOME, HOLD + 6);
    for (int i = 0; i < c; i++) press(M_RIGHT, HOLD + 6);
    for (int i = 0; i < r; i++) press(M_DOWN, HOLD + 6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: led_out=%h expected run to finish", led_out);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset state", 8'h80);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 idle after reset", 8'h80);

    // exhaustive sweep: every start position, every button
    for (int p = 0; p < 8; p++) begin
      for (int d = 0; d < 5; d++) begin
        logic [4:0] m;
        m = 5'b00001 << d;
        goto_pos(p % 4, p / 4);
        check("R2 position mapping", exp_led());
        press(m, HOLD + 6);
        case (d)
          0: check("R9 centre returns home", exp_led());
          1: check("R7 up with row saturation", exp_led());
          2: check("R8 down with row saturation", exp_led());
          3: check("R6 left with column saturation", exp_led());
          default: check("R5 right with column saturation", exp_led());
        endcase
      end
    end

    // short pulses ignored
    goto_pos(1, 0);
    press(M_DOWN, HOLD / 2);
    check("R3 short pulse ignored", exp_led());
    press(M_RIGHT, 2);
    check("R3 two-cycle glitch ignored", exp_led());

    // bounce before a real press yields one move
    for (int k = 0; k < 5; k++) begin
      btn = M_DOWN;
      repeat (3) @(negedge clk);
      btn = '0;
      repeat (2) @(negedge clk);
    end
    press(M_DOWN, HOLD + 6);
    check("R3 bounce then hold moves once", exp_led());

    // long hold does not repeat
    goto_pos(0, 0);
    press(M_DOWN, HOLD * 8);
    check("R4 long hold moves once", 8'h40);
    press(M_RIGHT, HOLD * 6);
    check("R4 long hold right moves once", 8'h04);

    // priority between simultaneous presses
    goto_pos(1, 1);
    press(M_HOME | M_RIGHT, HOLD + 6);
    check("R10 centre beats right", 8'h80);
    goto_pos(1, 0);
    press(M_UP | M_DOWN, HOLD + 6);
    check("R10 up beats down", 8'h80);
    goto_pos(1, 1);
    press(M_DOWN | M_LEFT, HOLD + 6);
    check("R10 down beats left", 8'h02);
    goto_pos(2, 1);
    press(M_LEFT | M_RIGHT, HOLD + 6);
    check("R10 left beats right", 8'h20);

    // reset from a non-home position, with a button held across it
    goto_pos(2, 1);
    btn = M_DOWN;
    repeat (HOLD + 6) @(negedge clk);
    model_apply(M_DOWN);
    check("R8 held press moved once", exp_led());
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 reset returns home", 8'h80);
    rst = 1'b0;
    repeat (HOLD + 6) @(negedge clk);
    btn = '0;
    repeat (HOLD + 8) @(negedge clk);
    check("R1 debounce cleared, held button accepted anew", 8'h40);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule